// File: doc/BRIEF.md
# Serial Bit-Clock Divider

This block produces the bit clock for a buffered serial port. It counts source ticks and divides them by a programmable 8-bit integer. A source tick is either every system clock cycle (internal source) or each synchronized rising edge of an external clock pin. The split between the high and low phases depends on whether the divisor is odd or even. A polarity input can invert the result. Next to the clock, the block gives the downstream shift logic a one-cycle strobe. The strobe marks each rising transition of the un-inverted bit clock.

The design runs entirely in the system clock domain. The bit clock is a registered level that changes only on source ticks, so the design never creates a derived clock. A new divisor or source selection is taken only at a period boundary. While enable is low, the output rests at its inactive level and the phase counter is cleared.

The sequencer has four states:
- **IDLE**: output low, counter clear.
- **HIGH**: counting the high phase.
- **LOW**: counting the low phase.
- **FOLLOW**: external source with a zero divisor; the output tracks the synchronized pin.

The transitions are:
- **start**: IDLE to HIGH or FOLLOW, on the first tick after enable.
- **half**: HIGH to LOW, when the high count expires.
- **reload**: LOW or FOLLOW to HIGH or FOLLOW, at a period boundary, where the divisor is latched again.
- **stop**: any state to IDLE, while enable is low.

Top module: `bclk_gen`

## Requirements
- R1: A period of the bit clock spans exactly divisor + 1 source ticks when the divisor is non-zero.
- R2: For an even, non-zero divisor, the high phase lasts divisor/2 + 1 ticks and the low phase lasts divisor/2 ticks.
- R3: For an odd divisor, the high and low phases each last (divisor + 1)/2 ticks.
- R4: With the internal source and a divisor of zero, the divisor is treated as 1: one cycle high, then one cycle low.
- R5: With the external source and a divisor of zero, the un-inverted output is high for as long as the synchronized pin is high, and low for as long as it is low.
- R6: When `int_src_i` is 1, a tick is every system cycle. When it is 0, a tick is each rising edge of `ext_clk_i` after a two-flop synchronizer. The pin must run slower than half the system clock.
- R7: When `invert_i` is 1, `bclk_o` is the complement of the un-inverted clock, and this includes the idle level.
- R8: A divisor change takes effect only at the next period boundary. The period in progress completes with the old high and low lengths.
- R9: One cycle after `en_i` is sampled low, `bclk_o` equals `invert_i` and `bclk_stb_o` is 0. The first period after enable begins with a full high phase. After reset, both outputs are 0 (with `invert_i` low).
- R10: `bclk_stb_o` is high for exactly the one system cycle in which the un-inverted clock has just risen, and in no other cycle.
- R11: With the internal source, a period is never shorter than two system cycles, so two strobes never fall in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the output inactive |
| int_src_i | input | 1 | 1 selects the system clock as the tick source, 0 selects the external pin |
| divisor_i | input | 8 | Divide value; latched at each period boundary |
| invert_i | input | 1 | 1 inverts the bit clock |
| ext_clk_i | input | 1 | External source clock pin (asynchronous) |
| bclk_o | output | 1 | Generated bit clock |
| bclk_stb_o | output | 1 | One-cycle strobe on each rising edge of the un-inverted clock |

## Verification
The divisor reload and a change of the divisor input can meet at the same edge. The period boundary latches whatever value is present at that edge. A change made earlier, inside the high phase, must not shorten or stretch the phase in progress.

The bench provokes this overlap in two ways. In one, it rewrites the divisor one sample after a rising edge. In the other, it changes the divisor while a period is running and the divisor is being reloaded in a later cycle. It then measures four consecutive phase lengths at the pins. The first period is judged against the old divisor and the second against the new one, with the expected lengths computed by bench functions. Across all runs, every strobe sample is compared with the rising transitions of the un-inverted clock.

// File: rtl/bclk_pkg.sv
`timescale 1ns/1ps
package bclk_pkg;

    // Sequencer states of the bit-clock generator
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_HIGH   = 2'd1,
        PH_LOW    = 2'd2,
        PH_FOLLOW = 2'd3
    } phase_e;

endpackage

// File: rtl/bclk_src_sync.sv
`timescale 1ns/1ps
// Synchronizes the external source pin and extracts its edges.
module bclk_src_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[0] <= 1'b0;
                else         chain_q[0] <= ext_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b0;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~last_q;
    assign fall_o  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/bclk_phase_calc.sv
`timescale 1ns/1ps
// Derives phase lengths (minus one) from the divisor and the source choice.
module bclk_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             int_src_i,
    output logic [DIV_W-1:0] div_eff_o,
    output logic             follow_o,
    output logic [DIV_W-1:0] hi_m1_o,
    output logic [DIV_W-1:0] lo_m1_o
);

    logic             zero;
    logic [DIV_W-1:0] half;

    always_comb begin
        zero      = (divisor_i == '0);
        follow_o  = zero && !int_src_i;
        // internal source never divides by less than two
        div_eff_o = (zero && int_src_i) ? DIV_W'(1) : divisor_i;
        half      = div_eff_o >> 1;
        hi_m1_o   = half;
        if (follow_o)          lo_m1_o = '0;
        else if (div_eff_o[0]) lo_m1_o = half;
        else                   lo_m1_o = half - DIV_W'(1);
    end

endmodule

// File: rtl/bclk_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: counts ticks through high and low phases.
module bclk_phase_fsm
    import bclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             int_src_i,
    input  logic             ext_rise_i,
    input  logic             ext_fall_i,
    input  logic             follow_i,
    input  logic [DIV_W-1:0] div_eff_i,
    input  logic [DIV_W-1:0] hi_m1_i,
    input  logic [DIV_W-1:0] lo_m1_i,
    output logic             raw_o,
    output logic             stb_o,
    output logic [DIV_W-1:0] div_act_o
);

    phase_e           state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lo_m1_q;
    logic [DIV_W-1:0] div_act_q;
    logic             src_act_q;
    logic             tick;
    logic             load;
    logic             raw_q, stb_q;

    // tick source: live selection while idle, latched one otherwise
    always_comb begin
        if (state_q == PH_IDLE) tick = int_src_i ? 1'b1 : ext_rise_i;
        else                    tick = src_act_q ? 1'b1 : ext_rise_i;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        if (!en_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (tick) load = 1'b1;
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            state_d = PH_LOW;
                            cnt_d   = lo_m1_q;
                        end else begin
                            cnt_d = cnt_q - DIV_W'(1);
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_q == '0) load = 1'b1;
                        else             cnt_d = cnt_q - DIV_W'(1);
                    end
                end
                PH_FOLLOW: begin
                    if (tick) load = 1'b1;
                end
                default: state_d = PH_IDLE;
            endcase
            if (load) begin
                state_d = follow_i ? PH_FOLLOW : PH_HIGH;
                cnt_d   = follow_i ? '0 : hi_m1_i;
            end
        end
    end

    // state register and period-boundary latches
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= PH_IDLE;
            cnt_q     <= '0;
            lo_m1_q   <= '0;
            div_act_q <= '0;
            src_act_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                lo_m1_q   <= lo_m1_i;
                div_act_q <= div_eff_i;
                src_act_q <= int_src_i;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            raw_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= load;
            unique case (state_d)
                PH_IDLE:   raw_q <= 1'b0;
                PH_HIGH:   raw_q <= 1'b1;
                PH_LOW:    raw_q <= 1'b0;
                PH_FOLLOW: raw_q <= load ? 1'b1 : (ext_fall_i ? 1'b0 : raw_q);
                default:   raw_q <= 1'b0;
            endcase
        end
    end

    assign raw_o     = raw_q;
    assign stb_o     = stb_q;
    assign div_act_o = div_act_q;

endmodule

// File: rtl/bclk_gen.sv
`timescale 1ns/1ps
// Serial bit-clock divider top level.
module bclk_gen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             int_src_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             invert_i,
    input  logic             ext_clk_i,
    output logic             bclk_o,
    output logic             bclk_stb_o
);

    localparam int CNT_W = DIV_W;

    logic             ext_level;
    logic             ext_rise;
    logic             ext_fall;
    logic             follow_w;
    logic [CNT_W-1:0] div_eff_w;
    logic [CNT_W-1:0] hi_m1_w;
    logic [CNT_W-1:0] lo_m1_w;
    logic [CNT_W-1:0] div_act_w;
    logic             raw_w;

    bclk_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ext_i   (ext_clk_i),
        .level_o (ext_level),
        .rise_o  (ext_rise),
        .fall_o  (ext_fall)
    );

    bclk_phase_calc #(.DIV_W(CNT_W)) u_calc (
        .divisor_i (divisor_i),
        .int_src_i (int_src_i),
        .div_eff_o (div_eff_w),
        .follow_o  (follow_w),
        .hi_m1_o   (hi_m1_w),
        .lo_m1_o   (lo_m1_w)
    );

    bclk_phase_fsm #(.DIV_W(CNT_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .int_src_i  (int_src_i),
        .ext_rise_i (ext_rise),
        .ext_fall_i (ext_fall),
        .follow_i   (follow_w),
        .div_eff_i  (div_eff_w),
        .hi_m1_i    (hi_m1_w),
        .lo_m1_i    (lo_m1_w),
        .raw_o      (raw_w),
        .stb_o      (bclk_stb_o),
        .div_act_o  (div_act_w)
    );

    logic unused_level;
    assign unused_level = ext_level;

    assign bclk_o = raw_w ^ invert_i;

endmodule

// File: rtl/bclk_gen_chk.sv
`timescale 1ns/1ps
// Property checker for bclk_gen, attached by bind below.
module bclk_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             raw,
    input logic             stb,
    input logic [DIV_W-1:0] div_act
);

    // R10: a strobe only accompanies a fresh rising edge
    p_stb_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> $rose(raw));

    // R10: every rising edge carries a strobe
    p_rise_has_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> stb);

    // R9: disable forces the inactive level and no strobe
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!raw && !stb));

    // R11: strobes never in adjacent cycles
    p_stb_spaced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R8: active divisor only changes at a period boundary
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |-> $stable(div_act));

endmodule

bind bclk_gen bclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .en      (en_i),
    .raw     (raw_w),
    .stb     (bclk_stb_o),
    .div_act (div_act_w)
);

// File: tb/bclk_gen_test.sv
`timescale 1ns/1ps
module bclk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       int_src = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       invert = 1'b0;
    logic       ext_clk = 1'b0;
    logic       bclk;
    logic       bclk_stb;

    int n_chk = 0;
    int n_bad = 0;
    int stb_err = 0;
    int ext_half = 2;
    bit done = 1'b0;
    logic raw_prev = 1'b0;

    bclk_gen uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .int_src_i  (int_src),
        .divisor_i  (divisor),
        .invert_i   (invert),
        .ext_clk_i  (ext_clk),
        .bclk_o     (bclk),
        .bclk_stb_o (bclk_stb)
    );

    always #4 clk = ~clk;

    // external source: square wave, 2*ext_half system cycles per period
    always begin
        repeat (ext_half) @(negedge clk);
        #2 ext_clk = ~ext_clk;
    end

    // R10 monitor: strobe must match a rise of the un-inverted clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (bclk_stb != ((bclk ^ invert) && !raw_prev)) stb_err++;
            raw_prev = bclk ^ invert;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(int d, bit s, int eh);
        int sp = s ? 1 : 2 * eh;
        if (d == 0) return s ? 1 : eh;
        return (d % 2 == 0) ? (d / 2 + 1) * sp : ((d + 1) / 2) * sp;
    endfunction

    function automatic int exp_lo(int d, bit s, int eh);
        int sp = s ? 1 : 2 * eh;
        if (d == 0) return s ? 1 : eh;
        return (d % 2 == 0) ? (d / 2) * sp : ((d + 1) / 2) * sp;
    endfunction

    function automatic string req_of(int d, bit s);
        if (!s) return (d == 0) ? "R5" : "R6";
        if (d == 0) return "R4";
        return (d % 2 == 0) ? "R2" : "R3";
    endfunction

    // count consecutive samples with un-inverted level v
    task automatic run_len(input bit v, output int n);
        n = 0;
        while (((bclk ^ invert) == v) && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input int d, input bit s, input bit p, input int eh, input int nd);
        int h1, l1, h2, l2, w;
        @(negedge clk);
        #1 en = 1'b0; int_src = s; invert = p; divisor = 8'(d); ext_half = eh;
        @(negedge clk);
        chk(bclk == p, p ? "R7 idle level" : "R9 idle level", int'(bclk), int'(p));
        chk(bclk_stb == 1'b0, "R9 idle strobe", int'(bclk_stb), 0);
        repeat (2 * eh + 4) @(negedge clk);
        #1 stb_err = 0; en = 1'b1;
        w = 0;
        while ((bclk ^ invert) != 1'b1 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 5000, "R9 start", w, 0);
        #1 divisor = 8'(nd);
        run_len(1'b1, h1);
        run_len(1'b0, l1);
        run_len(1'b1, h2);
        run_len(1'b0, l2);
        chk(h1 == exp_hi(d, s, eh), req_of(d, s), h1, exp_hi(d, s, eh));
        chk(l1 == exp_lo(d, s, eh), req_of(d, s), l1, exp_lo(d, s, eh));
        chk(h2 == exp_hi(nd, s, eh), (nd != d) ? "R8" : req_of(nd, s), h2, exp_hi(nd, s, eh));
        chk(l2 == exp_lo(nd, s, eh), (nd != d) ? "R8" : req_of(nd, s), l2, exp_lo(nd, s, eh));
        if (d != 0) chk(h1 + l1 == (d + 1) * (s ? 1 : 2 * eh), "R1", h1 + l1, (d + 1) * (s ? 1 : 2 * eh));
        if (s) chk(h1 + l1 >= 2, "R11", h1 + l1, 2);
        chk(stb_err == 0, "R10", stb_err, 0);
    endtask

    initial begin
        void'($urandom(32'h1bc5));
        repeat (3) @(negedge clk);
        chk(bclk == 1'b0, "R9 reset level", int'(bclk), 0);
        chk(bclk_stb == 1'b0, "R9 reset strobe", int'(bclk_stb), 0);
        #1 rst_n = 1'b1;
        // directed corners
        run_case(0, 1'b1, 1'b0, 2, 0);
        run_case(1, 1'b1, 1'b1, 2, 1);
        run_case(2, 1'b1, 1'b0, 2, 2);
        run_case(255, 1'b1, 1'b0, 2, 255);
        run_case(0, 1'b0, 1'b1, 3, 0);
        run_case(5, 1'b0, 1'b0, 2, 5);
        run_case(6, 1'b1, 1'b0, 2, 3);
        run_case(3, 1'b1, 1'b1, 2, 10);
        run_case(4, 1'b0, 1'b0, 2, 7);
        // constrained random
        for (int i = 0; i < 20; i++) begin
            int d  = int'($urandom_range(40, 0));
            bit s  = 1'($urandom_range(1, 0));
            bit p  = 1'($urandom_range(1, 0));
            int eh = int'($urandom_range(4, 2));
            int nd = ($urandom_range(3, 0) == 0 && d != 0) ? int'($urandom_range(40, 1)) : d;
            run_case(d, s, p, eh, nd);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule